// File: doc/BRIEF.md
# Late Sample Record Filter

This block sits at the end of a performance-sampling path and decides, one record at a time, whether a finished sample record is worth keeping. A kept record goes on to be stored or to raise an interrupt. A dropped record simply disappears, and nothing downstream sees it. Filtering in hardware saves the cost of an interrupt or a memory write for records that software would throw away anyway.

Each record carries a vector of general fields, a vector of event bits, several latency counters packed side by side, and an address field. The general fields and the event bits are each tested with a mask-and-match rule. One latency counter, chosen by a select setting, is compared against a free-valued threshold. The address field is carried through unchanged and plays no part in the decision. The verdict is registered and appears one cycle after the record's valid strobe, alongside a registered copy of the record.

Top module: `sfilt_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_vld, out_keep and out_drop are all low.
- R2: out_vld is high in exactly the cycles that follow a cycle with in_vld high. A cycle without in_vld produces neither a keep nor a drop in the next cycle.
- R3: The general check passes when (in_gen AND cfg_gen_mask) equals (cfg_gen_match AND cfg_gen_mask). An all-zero cfg_gen_mask always passes.
- R4: The event check applies the same rule to in_evt with cfg_evt_mask and cfg_evt_match. An all-zero cfg_evt_mask always passes.
- R5: cfg_lat_sel = k selects latency counter k, which occupies bits [k*LAT_W +: LAT_W] of in_lat. The other counters have no effect on the verdict.
- R6: The latency check passes when the selected counter is greater than or equal to cfg_lat_thresh, compared as unsigned values. A threshold of zero always passes.
- R7: A record is kept (out_keep high) only when the general, event and latency checks all pass. Otherwise it is dropped (out_drop high). When out_vld is high, exactly one of out_keep and out_drop is high.
- R8: in_addr never changes the verdict.
- R9: out_gen, out_evt, out_lat and out_addr equal the record accepted in the previous cycle, and they hold their value through cycles without in_vld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A finished record is present this cycle |
| in_gen | input | GEN_W | General fields of the record |
| in_evt | input | EVT_W | Event bits of the record |
| in_lat | input | NUM_LAT*LAT_W | Latency counters; counter k sits at [k*LAT_W +: LAT_W] |
| in_addr | input | ADDR_W | Address field, passed through only |
| cfg_gen_mask | input | GEN_W | Bits of the general fields that take part in the compare |
| cfg_gen_match | input | GEN_W | Required values of the general fields |
| cfg_evt_mask | input | EVT_W | Event bits that take part in the compare |
| cfg_evt_match | input | EVT_W | Required values of the event bits |
| cfg_lat_sel | input | clog2(NUM_LAT) | Index of the latency counter under test |
| cfg_lat_thresh | input | LAT_W | Minimum latency for a kept record |
| out_vld | output | 1 | A verdict is present this cycle |
| out_keep | output | 1 | Record passed all checks |
| out_drop | output | 1 | Record failed at least one check |
| out_gen | output | GEN_W | Registered general fields |
| out_evt | output | EVT_W | Registered event bits |
| out_lat | output | NUM_LAT*LAT_W | Registered latency counters |
| out_addr | output | ADDR_W | Registered address field |

## Verification
The bench builds the block with 4 general bits, 3 event bits, two 4-bit latency counters and an 8-bit address. At that size every combination of mask, match and field value for the general check (4096 records) and for the event check (512 records) can be swept. Every threshold is tried against every value of both selectable counters while the other counter holds the complementary value, and all 256 addresses are tried against both a passing and a failing configuration. A long pseudo-random run then changes all settings at once, and separate checks cover the verdict outputs when in_vld is low.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;

   // Width of an index that addresses n entries (at least one bit).
   function automatic int selw(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Registered verdict carried by the output stage.
   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_KEEP = 2'd1,
      VERD_DROP = 2'd2
   } verdict_e;

endpackage

// File: rtl/sfilt_maskmatch.sv
// Per-bit mask-and-match test; a cleared mask bit ignores that bit.
module sfilt_maskmatch #(
   parameter int W = 8
) (
   input  logic [W-1:0] fld,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] match,
   output logic         hit
);

   logic [W-1:0] miss;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign miss[b] = mask[b] & (fld[b] ^ match[b]);
   end

   assign hit = ~|miss;

endmodule

// File: rtl/sfilt_latsel.sv
// Picks one latency counter out of a packed bus and tests it
// against an unsigned threshold; threshold zero always passes.
module sfilt_latsel #(
   parameter int LAT_W   = 16,
   parameter int NUM_LAT = 4,
   localparam int SEL_W  = sfilt_pkg::selw(NUM_LAT)
) (
   input  logic [NUM_LAT*LAT_W-1:0] lat_bus,
   input  logic [SEL_W-1:0]         sel,
   input  logic [LAT_W-1:0]         thresh,
   output logic                     pass
);

   logic [LAT_W-1:0] lat_arr [NUM_LAT];
   logic [LAT_W-1:0] picked;
   logic             thr_off;

   for (genvar k = 0; k < NUM_LAT; k++) begin : g_unpack
      assign lat_arr[k] = lat_bus[k*LAT_W +: LAT_W];
   end

   assign picked  = lat_arr[sel];
   assign thr_off = (thresh == '0);
   assign pass    = thr_off | (picked >= thresh);

endmodule

// File: rtl/sfilt_top.sv
// Late filter for finished sample records: mask-and-match on the
// general fields and event bits, threshold on one selected latency,
// registered verdict one cycle after the valid strobe.
module sfilt_top #(
   parameter int GEN_W   = 16,
   parameter int EVT_W   = 8,
   parameter int LAT_W   = 16,
   parameter int NUM_LAT = 4,
   parameter int ADDR_W  = 64
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_vld,
   input  logic [GEN_W-1:0]                       in_gen,
   input  logic [EVT_W-1:0]                       in_evt,
   input  logic [NUM_LAT*LAT_W-1:0]               in_lat,
   input  logic [ADDR_W-1:0]                      in_addr,
   input  logic [GEN_W-1:0]                       cfg_gen_mask,
   input  logic [GEN_W-1:0]                       cfg_gen_match,
   input  logic [EVT_W-1:0]                       cfg_evt_mask,
   input  logic [EVT_W-1:0]                       cfg_evt_match,
   input  logic [sfilt_pkg::selw(NUM_LAT)-1:0]    cfg_lat_sel,
   input  logic [LAT_W-1:0]                       cfg_lat_thresh,
   output logic                                   out_vld,
   output logic                                   out_keep,
   output logic                                   out_drop,
   output logic [GEN_W-1:0]                       out_gen,
   output logic [EVT_W-1:0]                       out_evt,
   output logic [NUM_LAT*LAT_W-1:0]               out_lat,
   output logic [ADDR_W-1:0]                      out_addr
);

   import sfilt_pkg::*;

   localparam int LBUS_W = NUM_LAT * LAT_W;

   // Elaboration-time parameter checks
   if (GEN_W < 1 || EVT_W < 1 || LAT_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("sfilt_top: all field widths must be at least 1");
   end
   if (NUM_LAT < 2 || (NUM_LAT & (NUM_LAT - 1)) != 0) begin : g_bad_count
      $error("sfilt_top: NUM_LAT must be a power of two, at least 2");
   end

   logic gen_ok, evt_ok, lat_ok, all_ok;

   sfilt_maskmatch #(.W(GEN_W)) u_gen_mm (
      .fld   (in_gen),
      .mask  (cfg_gen_mask),
      .match (cfg_gen_match),
      .hit   (gen_ok)
   );

   sfilt_maskmatch #(.W(EVT_W)) u_evt_mm (
      .fld   (in_evt),
      .mask  (cfg_evt_mask),
      .match (cfg_evt_match),
      .hit   (evt_ok)
   );

   sfilt_latsel #(.LAT_W(LAT_W), .NUM_LAT(NUM_LAT)) u_lat (
      .lat_bus (in_lat),
      .sel     (cfg_lat_sel),
      .thresh  (cfg_lat_thresh),
      .pass    (lat_ok)
   );

   assign all_ok = gen_ok & evt_ok & lat_ok;

   // Verdict register
   verdict_e verd_q, verd_d;

   always_comb begin
      if (!in_vld)     verd_d = VERD_NONE;
      else if (all_ok) verd_d = VERD_KEEP;
      else             verd_d = VERD_DROP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) verd_q <= VERD_NONE;
      else        verd_q <= verd_d;
   end

   assign out_vld  = (verd_q != VERD_NONE);
   assign out_keep = (verd_q == VERD_KEEP);
   assign out_drop = (verd_q == VERD_DROP);

   // Record pass-through register, loaded only with a valid record
   logic [GEN_W-1:0]  gen_q;
   logic [EVT_W-1:0]  evt_q;
   logic [LBUS_W-1:0] lat_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q  <= '0;
         evt_q  <= '0;
         lat_q  <= '0;
         addr_q <= '0;
      end else if (in_vld) begin
         gen_q  <= in_gen;
         evt_q  <= in_evt;
         lat_q  <= in_lat;
         addr_q <= in_addr;
      end
   end

   assign out_gen  = gen_q;
   assign out_evt  = evt_q;
   assign out_lat  = lat_q;
   assign out_addr = addr_q;

endmodule

// File: rtl/sfilt_chk.sv
// Property checker attached to sfilt_top.
module sfilt_chk #(
   parameter int GEN_W  = 16,
   parameter int EVT_W  = 8,
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [GEN_W-1:0]  in_gen,
   input logic [EVT_W-1:0]  in_evt,
   input logic [ADDR_W-1:0] in_addr,
   input logic [GEN_W-1:0]  cfg_gen_mask,
   input logic [GEN_W-1:0]  cfg_gen_match,
   input logic [EVT_W-1:0]  cfg_evt_mask,
   input logic [EVT_W-1:0]  cfg_evt_match,
   input logic              out_vld,
   input logic              out_keep,
   input logic              out_drop,
   input logic [GEN_W-1:0]  out_gen,
   input logic [ADDR_W-1:0] out_addr
);

   p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && !out_keep && !out_drop));

   p_gen_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && ((in_gen & cfg_gen_mask) != (cfg_gen_match & cfg_gen_mask)))
      |=> out_drop);

   p_evt_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && ((in_evt & cfg_evt_mask) != (cfg_evt_match & cfg_evt_mask)))
      |=> out_drop);

   p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $onehot({out_keep, out_drop}));

   p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (out_gen == $past(in_gen) && out_addr == $past(in_addr)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_gen) && $stable(out_addr)));

endmodule

bind sfilt_top sfilt_chk #(
   .GEN_W  (GEN_W),
   .EVT_W  (EVT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_vld        (in_vld),
   .in_gen        (in_gen),
   .in_evt        (in_evt),
   .in_addr       (in_addr),
   .cfg_gen_mask  (cfg_gen_mask),
   .cfg_gen_match (cfg_gen_match),
   .cfg_evt_mask  (cfg_evt_mask),
   .cfg_evt_match (cfg_evt_match),
   .out_vld       (out_vld),
   .out_keep      (out_keep),
   .out_drop      (out_drop),
   .out_gen       (out_gen),
   .out_addr      (out_addr)
);

// File: tb/tb_sfilt_top.sv
module tb_sfilt_top;

   localparam int CLK_PERIOD = 10;
   localparam int GW = 4;
   localparam int EW = 3;
   localparam int LW = 4;
   localparam int NL = 2;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [GW-1:0] in_gen = '0;
   logic [EW-1:0] in_evt = '0;
   logic [NL*LW-1:0] in_lat = '0;
   logic [AW-1:0] in_addr = '0;
   logic [GW-1:0] gmask = '0, gmatch = '0;
   logic [EW-1:0] emask = '0, ematch = '0;
   logic          lsel = 1'b0;
   logic [LW-1:0] thr = '0;
   logic          out_vld, out_keep, out_drop;
   logic [GW-1:0] out_gen;
   logic [EW-1:0] out_evt;
   logic [NL*LW-1:0] out_lat;
   logic [AW-1:0] out_addr;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] lf = 32'h1ACE_B00C;

   sfilt_top #(.GEN_W(GW), .EVT_W(EW), .LAT_W(LW), .NUM_LAT(NL), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_gen(in_gen), .in_evt(in_evt),
      .in_lat(in_lat), .in_addr(in_addr), .cfg_gen_mask(gmask), .cfg_gen_match(gmatch),
      .cfg_evt_mask(emask), .cfg_evt_match(ematch), .cfg_lat_sel(lsel),
      .cfg_lat_thresh(thr), .out_vld(out_vld), .out_keep(out_keep), .out_drop(out_drop),
      .out_gen(out_gen), .out_evt(out_evt), .out_lat(out_lat), .out_addr(out_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   // Expected verdict derived from the requirement text.
   function automatic bit want_keep();
      logic [LW-1:0] l;
      bit g, e, t;
      l = lsel ? in_lat[LW +: LW] : in_lat[0 +: LW];
      g = ((in_gen & gmask) == (gmatch & gmask));
      e = ((in_evt & emask) == (ematch & emask));
      t = (thr == 0) || (l >= thr);
      return g && e && t;
   endfunction

   // Inputs and configuration are already set; strobe one record,
   // then check the verdict and the pass-through one cycle later.
   task automatic send(input string req);
      bit k;
      logic [GW+EW+NL*LW+AW-1:0] rec;
      @(negedge clk);
      in_vld = 1'b1;
      k = want_keep();
      rec = {in_gen, in_evt, in_lat, in_addr};
      @(negedge clk);
      chk(out_vld && (out_keep == k) && (out_drop == !k), req,
          {61'd0, out_vld, out_keep, out_drop}, {61'd0, 1'b1, k, !k});
      chk({out_gen, out_evt, out_lat, out_addr} == rec, "R9 pass-through",
          64'({out_gen, out_evt, out_lat, out_addr}), 64'(rec));
      in_vld = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [GW+EW+NL*LW+AW-1:0] held;
      // R1: reset state, with a record strobed during reset
      in_vld = 1'b1;
      repeat (3) @(negedge clk);
      chk(!out_vld && !out_keep && !out_drop, "R1 during reset",
          {61'd0, out_vld, out_keep, out_drop}, 64'd0);
      in_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_vld && !out_keep && !out_drop, "R1 after release",
          {61'd0, out_vld, out_keep, out_drop}, 64'd0);

      // R3: exhaustive general mask/match sweep
      for (int m = 0; m < 16; m++)
         for (int t = 0; t < 16; t++)
            for (int f = 0; f < 16; f++) begin
               gmask = GW'(m); gmatch = GW'(t); in_gen = GW'(f);
               send("R3 general mask-match");
            end
      gmask = '0;

      // R4: exhaustive event mask/match sweep
      for (int m = 0; m < 8; m++)
         for (int t = 0; t < 8; t++)
            for (int f = 0; f < 8; f++) begin
               emask = EW'(m); ematch = EW'(t); in_evt = EW'(f);
               send("R4 event mask-match");
            end
      emask = '0;

      // R5/R6: every threshold against every value of the selected counter
      for (int s = 0; s < 2; s++)
         for (int th = 0; th < 16; th++)
            for (int v = 0; v < 16; v++) begin
               lsel = s[0]; thr = LW'(th);
               if (s == 0) in_lat = {LW'(15 - v), LW'(v)};
               else        in_lat = {LW'(v), LW'(15 - v)};
               send("R5 R6 latency select and threshold");
            end
      thr = '0;

      // R8: address swept against a passing and a failing setup
      gmask = 4'b1010; gmatch = 4'b1000;
      for (int a = 0; a < 256; a++) begin
         in_addr = AW'(a); in_gen = 4'b1101;
         send("R8 address ignored (keep)");
         in_gen = 4'b0101;
         send("R8 address ignored (drop)");
      end

      // R7: all settings varied together
      for (int i = 0; i < 1500; i++) begin
         lf = nxt(lf); gmask = lf[3:0]; gmatch = lf[7:4]; in_gen = lf[11:8];
         emask = lf[14:12]; ematch = lf[17:15]; in_evt = lf[20:18]; lsel = lf[21];
         lf = nxt(lf); in_lat = lf[7:0]; thr = lf[11:8]; in_addr = lf[19:12];
         send("R7 combined verdict");
      end

      // R2/R9: idle cycles give no verdict and hold the record
      gmask = '0; emask = '0; thr = '0;
      send("R7 all checks off keeps");
      held = {out_gen, out_evt, out_lat, out_addr};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_gen = GW'(i + 3); in_addr = AW'(i * 37);
         @(negedge clk);
         chk(!out_vld && !out_keep && !out_drop, "R2 no strobe no verdict",
             {61'd0, out_vld, out_keep, out_drop}, 64'd0);
         chk({out_gen, out_evt, out_lat, out_addr} == held, "R9 hold while idle",
             64'({out_gen, out_evt, out_lat, out_addr}), 64'(held));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule